// File: doc/BRIEF.md
# Top-Relative Register Stack

This block holds the operand registers of a stack-oriented floating-point datapath. It has eight slots arranged in a ring. A 3-bit top pointer names the slot that acts as the accumulator ST(0). Every other operand is addressed as ST(i), which is the slot i places above the top, wrapping modulo 8. A push moves the top down one slot and fills it. A pop empties the top slot and moves the top up one slot. The arithmetic unit sits outside the block. It reads ST(0) and ST(i) on combinational ports and returns its result on an input port. Each operation chooses whether that result lands in ST(0) or in ST(i).

Each slot carries a valid tag. The block raises an overflow pulse when a push would land on a slot that is still valid. It raises an underflow pulse when an operation needs a slot that is empty. When either error occurs, nothing in the stack changes for that cycle.

A second, independent request can swap ST(0) with ST(j) in the same cycle as the main operation. The swap is applied after the main operation and uses the top that the main operation leaves behind. This lets an exchange ride along with an arithmetic writeback at no extra cycle cost.

Top module: `rstack_top`

## Requirements
- R1: After reset the top pointer is 0, every slot is empty (both valid outputs 0), and `ovf_o` and `unf_o` are 0.
- R2: `st0_o` and `st0_vld_o` show the slot at the top pointer. `sti_o` and `sti_vld_o` show the slot at (top + `idx_i`) mod 8. Both are combinational from current state.
- R3: PUSH (`op_i`=1) onto an empty slot does three things: the top becomes (top − 1) mod 8, `push_data_i` is stored there, and that slot becomes valid.
- R4: PUSH when slot (top − 1) mod 8 is valid raises `ovf_o` in the next cycle and changes neither the top, the tags nor the data.
- R5: POP (`op_i`=2) of a valid ST(0) marks that slot empty and sets the top to (top + 1) mod 8.
- R6: POP when ST(0) is empty raises `unf_o` in the next cycle and leaves the stack untouched.
- R7: ARITH (`op_i`=3) with ST(0) and ST(i) both valid writes `result_i` to ST(0) when `rev_i`=0, leaving ST(i) unchanged. When `rev_i`=1 it writes ST(i) instead, leaving ST(0) unchanged. The top and the tags do not move.
- R8: ARITH_MEM (`op_i`=5) needs only ST(0) to be valid and writes `result_i` to ST(0). An ARITH, ARITH_MEM or ARITH_POP whose operands are not all valid raises `unf_o` and changes nothing.
- R9: ARITH_POP (`op_i`=4) writes `result_i` to ST(i) and then pops, so the result reads back as ST(i−1) afterwards. When i=0 the written slot is the one that is emptied.
- R10: With `swap_en_i`=1, the contents of ST(0) and ST(`swap_idx_i`) are exchanged in the same cycle. The swap is taken relative to the top after the main operation and acts on the values that operation wrote.
- R11: A swap whose two slots are not both valid after the main operation raises `unf_o` and cancels the whole cycle, main operation included.
- R12: `ovf_o` and `unf_o` are one-cycle pulses, high only in the cycle after the faulting request, and never high together. Op code 0 (NOP) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation: 0 NOP, 1 PUSH, 2 POP, 3 ARITH, 4 ARITH_POP, 5 ARITH_MEM |
| idx_i | input | 3 | Top-relative index i of the second operand |
| rev_i | input | 1 | ARITH destination: 0 ST(0), 1 ST(i) |
| push_data_i | input | DATA_W | Value stored by PUSH |
| result_i | input | DATA_W | Result from the external arithmetic unit |
| swap_en_i | input | 1 | Request a swap of ST(0) with ST(swap_idx_i) |
| swap_idx_i | input | 3 | Top-relative index of the swap partner |
| st0_o | output | DATA_W | Contents of ST(0) |
| sti_o | output | DATA_W | Contents of ST(idx_i) |
| st0_vld_o | output | 1 | Tag of ST(0) |
| sti_vld_o | output | 1 | Tag of ST(idx_i) |
| top_o | output | 3 | Physical slot of the top |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |

## Verification
The bench wraps the top pointer through slot 7 to slot 0. A design that forgot the modulo arithmetic would address the wrong slot or lose the eighth push. It fills all eight slots and pushes once more, to catch an overflow that overwrites data or moves the top. It drains the stack and pops past empty, to catch an underflow that still clears a tag. Paired swaps are combined with PUSH, ARITH and ARITH_POP. A design that swapped relative to the old top, or before the writeback, would show the result in the wrong slot. A swap that names an empty slot must also cancel the main write. A random phase then compares every port against a behavioural model every cycle.

// File: rtl/rstack_pkg.sv
package rstack_pkg;
  parameter int unsigned PTR_W = 3;
  localparam int unsigned DEPTH = 1 << PTR_W;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_PUSH      = 3'd1,
    OP_POP       = 3'd2,
    OP_ARITH     = 3'd3,
    OP_ARITH_POP = 3'd4,
    OP_ARITH_MEM = 3'd5
  } rs_op_e;

  // physical slot of ST(rel) for a given top, wrapping over the ring
  function automatic ptr_t slot_of(input ptr_t top, input ptr_t rel);
    return ptr_t'(top + rel);
  endfunction

  function automatic ptr_t ptr_inc(input ptr_t p);
    return ptr_t'(p + ptr_t'(1));
  endfunction

  function automatic ptr_t ptr_dec(input ptr_t p);
    return ptr_t'(p - ptr_t'(1));
  endfunction
endpackage

// File: rtl/rstack_ctrl.sv
module rstack_ctrl
  import rstack_pkg::*;
(
  input  logic [2:0]       op_i,
  input  ptr_t             idx_i,
  input  logic             rev_i,
  input  logic             swap_en_i,
  input  ptr_t             swap_idx_i,
  input  ptr_t             top_q_i,
  input  logic [DEPTH-1:0] tag_q_i,
  output ptr_t             top_d_o,
  output logic             wr_en_o,
  output ptr_t             wr_slot_o,
  output logic             wr_push_o,
  output logic             clr_en_o,
  output ptr_t             clr_slot_o,
  output logic             swp_en_o,
  output ptr_t             swp_a_o,
  output ptr_t             swp_b_o,
  output logic             ovf_d_o,
  output logic             unf_d_o
);
  ptr_t             s0, si, sp, top_n;
  logic             v0, vi;
  logic             ovf, unf;
  logic             wr_en, wr_push, clr_en, swp;
  ptr_t             wr_slot, clr_slot, sa, sb;
  logic [DEPTH-1:0] tag_post;

  assign s0 = top_q_i;
  assign si = slot_of(top_q_i, idx_i);
  assign sp = ptr_dec(top_q_i);
  assign v0 = tag_q_i[s0];
  assign vi = tag_q_i[si];

  always_comb begin
    ovf      = 1'b0;
    unf      = 1'b0;
    wr_en    = 1'b0;
    wr_push  = 1'b0;
    wr_slot  = s0;
    clr_en   = 1'b0;
    clr_slot = s0;
    top_n    = top_q_i;
    case (op_i)
      OP_PUSH: begin
        if (tag_q_i[sp]) ovf = 1'b1;
        else begin
          wr_en   = 1'b1;
          wr_push = 1'b1;
          wr_slot = sp;
          top_n   = sp;
        end
      end
      OP_POP: begin
        if (!v0) unf = 1'b1;
        else begin
          clr_en = 1'b1;
          top_n  = ptr_inc(s0);
        end
      end
      OP_ARITH: begin
        if (!(v0 && vi)) unf = 1'b1;
        else begin
          wr_en   = 1'b1;
          wr_slot = rev_i ? si : s0;
        end
      end
      OP_ARITH_POP: begin
        if (!(v0 && vi)) unf = 1'b1;
        else begin
          wr_en   = 1'b1;
          wr_slot = si;
          clr_en  = 1'b1;
          top_n   = ptr_inc(s0);
        end
      end
      OP_ARITH_MEM: begin
        if (!v0) unf = 1'b1;
        else wr_en = 1'b1;
      end
      default: ;
    endcase

    // tags as the main operation leaves them; a clear wins over a set
    tag_post = tag_q_i;
    if (wr_push) tag_post[wr_slot] = 1'b1;
    if (clr_en)  tag_post[clr_slot] = 1'b0;

    sa  = top_n;
    sb  = slot_of(top_n, swap_idx_i);
    swp = 1'b0;
    if (swap_en_i && !ovf && !unf) begin
      if (tag_post[sa] && tag_post[sb]) swp = 1'b1;
      else unf = 1'b1;
    end

    if (ovf || unf) begin
      wr_en   = 1'b0;
      wr_push = 1'b0;
      clr_en  = 1'b0;
      swp     = 1'b0;
      top_n   = top_q_i;
    end
  end

  assign top_d_o    = top_n;
  assign wr_en_o    = wr_en;
  assign wr_slot_o  = wr_slot;
  assign wr_push_o  = wr_push;
  assign clr_en_o   = clr_en;
  assign clr_slot_o = clr_slot;
  assign swp_en_o   = swp;
  assign swp_a_o    = sa;
  assign swp_b_o    = sb;
  assign ovf_d_o    = ovf;
  assign unf_d_o    = unf;
endmodule

// File: rtl/rstack_slots.sv
module rstack_slots
  import rstack_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  ptr_t              wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              set_tag_i,
  input  logic              clr_en_i,
  input  ptr_t              clr_slot_i,
  input  logic              swp_en_i,
  input  ptr_t              swp_a_i,
  input  ptr_t              swp_b_i,
  input  ptr_t              rd_a_i,
  input  ptr_t              rd_b_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  output logic [DEPTH-1:0]  tag_o
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DATA_W-1:0] post_w [DEPTH];
  logic [DATA_W-1:0] data_n [DEPTH];
  logic [DEPTH-1:0]  tag_q, tag_w, tag_n;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam ptr_t SLOT = ptr_t'(g);

    // stage 1: main writeback and tag update
    always_comb begin
      post_w[g] = data_q[g];
      tag_w[g]  = tag_q[g];
      if (wr_en_i && wr_slot_i == SLOT) post_w[g] = wr_data_i;
      if (set_tag_i && wr_slot_i == SLOT) tag_w[g] = 1'b1;
      if (clr_en_i && clr_slot_i == SLOT) tag_w[g] = 1'b0;
    end

    // stage 2: exchange on top of the written values
    always_comb begin
      data_n[g] = post_w[g];
      tag_n[g]  = tag_w[g];
      if (swp_en_i && swp_a_i == SLOT) begin
        data_n[g] = post_w[swp_b_i];
        tag_n[g]  = tag_w[swp_b_i];
      end else if (swp_en_i && swp_b_i == SLOT) begin
        data_n[g] = post_w[swp_a_i];
        tag_n[g]  = tag_w[swp_a_i];
      end
    end

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        tag_q[g]  <= 1'b0;
      end else begin
        data_q[g] <= data_n[g];
        tag_q[g]  <= tag_n[g];
      end
    end
  end

  assign rd_a_o = data_q[rd_a_i];
  assign rd_b_o = data_q[rd_b_i];
  assign tag_o  = tag_q;

  // R10
  swap_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swp_en_i |=> (data_q[$past(swp_a_i)] == $past(post_w[swp_b_i]))
              && (data_q[$past(swp_b_i)] == $past(post_w[swp_a_i])));

  // R3
  push_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_tag_i && !swp_en_i) |=> tag_q[$past(wr_slot_i)]);

  // R5
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !swp_en_i) |=> !tag_q[$past(clr_slot_i)]);
endmodule

// File: rtl/rstack_top.sv
module rstack_top
  import rstack_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [2:0]        idx_i,
  input  logic              rev_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              swap_en_i,
  input  logic [2:0]        swap_idx_i,
  output logic [DATA_W-1:0] st0_o,
  output logic [DATA_W-1:0] sti_o,
  output logic              st0_vld_o,
  output logic              sti_vld_o,
  output logic [2:0]        top_o,
  output logic              ovf_o,
  output logic              unf_o
);
  ptr_t             top_q, top_d;
  logic             ovf_q, unf_q, ovf_d, unf_d;
  logic [DEPTH-1:0] tag_q;
  logic             wr_en, wr_push, clr_en, swp_en;
  ptr_t             wr_slot, clr_slot, swp_a, swp_b, rd_i;
  logic [DATA_W-1:0] wr_data;

  rstack_ctrl u_ctrl (
    .op_i       (op_i),
    .idx_i      (idx_i),
    .rev_i      (rev_i),
    .swap_en_i  (swap_en_i),
    .swap_idx_i (swap_idx_i),
    .top_q_i    (top_q),
    .tag_q_i    (tag_q),
    .top_d_o    (top_d),
    .wr_en_o    (wr_en),
    .wr_slot_o  (wr_slot),
    .wr_push_o  (wr_push),
    .clr_en_o   (clr_en),
    .clr_slot_o (clr_slot),
    .swp_en_o   (swp_en),
    .swp_a_o    (swp_a),
    .swp_b_o    (swp_b),
    .ovf_d_o    (ovf_d),
    .unf_d_o    (unf_d)
  );

  assign wr_data = wr_push ? push_data_i : result_i;
  assign rd_i    = slot_of(top_q, idx_i);

  rstack_slots #(.DATA_W(DATA_W)) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_slot_i  (wr_slot),
    .wr_data_i  (wr_data),
    .set_tag_i  (wr_push),
    .clr_en_i   (clr_en),
    .clr_slot_i (clr_slot),
    .swp_en_i   (swp_en),
    .swp_a_i    (swp_a),
    .swp_b_i    (swp_b),
    .rd_a_i     (top_q),
    .rd_b_i     (rd_i),
    .rd_a_o     (st0_o),
    .rd_b_o     (sti_o),
    .tag_o      (tag_q)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      top_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      top_q <= top_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign st0_vld_o = tag_q[top_q];
  assign sti_vld_o = tag_q[rd_i];
  assign top_o     = top_q;
  assign ovf_o     = ovf_q;
  assign unf_o     = unf_q;

  // R4
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_d || unf_d) |=> (top_q == $past(top_q)) && $stable(tag_q));

  // R12
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_q, unf_q}));

  // R3
  push_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && !ovf_d && !unf_d) |=> top_q == ptr_dec($past(top_q)));

  // R5
  pop_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_POP || op_i == OP_ARITH_POP) && !unf_d) |=> top_q == ptr_inc($past(top_q)));

  // R12
  nop_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NOP && !swap_en_i) |=> $stable(tag_q) && $stable(top_q) && !ovf_q && !unf_q);
endmodule

// File: tb/rstack_top_tb_top.sv
`timescale 1ns/1ps
module rstack_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0, idx = '0, sidx = '0;
  logic        rev = 1'b0, swen = 1'b0;
  logic [31:0] pdat = '0, res = '0;
  logic [31:0] st0, sti;
  logic        v0, vi, ovf, unf;
  logic [2:0]  top;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference: eight cells, a top index, tags
  logic [31:0] m_dat [8];
  bit          m_tag [8];
  int          m_top;

  always #2 clk = ~clk;

  rstack_top #(.DATA_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .idx_i(idx), .rev_i(rev),
    .push_data_i(pdat), .result_i(res), .swap_en_i(swen), .swap_idx_i(sidx),
    .st0_o(st0), .sti_o(sti), .st0_vld_o(v0), .sti_vld_o(vi),
    .top_o(top), .ovf_o(ovf), .unf_o(unf));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int rel(input int t, input int i);
    return (t + i) % 8;
  endfunction

  task automatic step(input string req, input int o, input int i, input bit rv,
                      input logic [31:0] pd, input logic [31:0] r, input bit sw, input int sj);
    logic [31:0] nd [8];
    bit nt [8];
    int nt_top;
    bit eo, eu;
    logic [31:0] tmp;
    bit tb;
    op = 3'(o); idx = 3'(i); rev = rv; pdat = pd; res = r; swen = sw; sidx = 3'(sj);
    #1;
    // R2 read ports from the state before the edge
    chk(req, "st0", st0, m_dat[m_top]);
    chk(req, "sti", sti, m_dat[rel(m_top, i)]);
    chk(req, "st0_vld", 32'(v0), 32'(m_tag[m_top]));
    chk(req, "sti_vld", 32'(vi), 32'(m_tag[rel(m_top, i)]));
    nd = m_dat; nt = m_tag; nt_top = m_top; eo = 0; eu = 0;
    case (o)
      1: if (m_tag[rel(m_top, 7)]) eo = 1;
         else begin nt_top = rel(m_top, 7); nd[nt_top] = pd; nt[nt_top] = 1; end
      2: if (!m_tag[m_top]) eu = 1;
         else begin nt[m_top] = 0; nt_top = rel(m_top, 1); end
      3: if (!m_tag[m_top] || !m_tag[rel(m_top, i)]) eu = 1;
         else nd[rv ? rel(m_top, i) : m_top] = r;
      4: if (!m_tag[m_top] || !m_tag[rel(m_top, i)]) eu = 1;
         else begin nd[rel(m_top, i)] = r; nt[m_top] = 0; nt_top = rel(m_top, 1); end
      5: if (!m_tag[m_top]) eu = 1; else nd[m_top] = r;
      default: ;
    endcase
    if (sw && !eo && !eu) begin
      if (!nt[nt_top] || !nt[rel(nt_top, sj)]) eu = 1;
      else begin
        tmp = nd[nt_top]; nd[nt_top] = nd[rel(nt_top, sj)]; nd[rel(nt_top, sj)] = tmp;
        tb = nt[nt_top]; nt[nt_top] = nt[rel(nt_top, sj)]; nt[rel(nt_top, sj)] = tb;
      end
    end
    if (!eo && !eu) begin m_dat = nd; m_tag = nt; m_top = nt_top; end
    @(posedge clk); #1;
    chk(req, "top", 32'(top), 32'(m_top));
    chk(req, "ovf", 32'(ovf), 32'(eo));
    chk(req, "unf", 32'(unf), 32'(eu));
    @(negedge clk);
  endtask

  task automatic scan(input string req);
    for (int k = 0; k < 8; k++) step(req, 0, k, 0, '0, '0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m_dat[k] = '0; m_tag[k] = 0; end
    m_top = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "top", 32'(top), 0);
    chk("R1", "ovf", 32'(ovf), 0);
    chk("R1", "unf", 32'(unf), 0);
    scan("R1");
    // R6 pop on empty, R8 arith on empty
    step("R6", 2, 0, 0, '0, '0, 0, 0);
    step("R8", 3, 1, 0, '0, 32'hdead, 0, 0);
    step("R8", 5, 0, 0, '0, 32'hdead, 0, 0);
    // R3 push through the wrap, fill all eight slots
    for (int k = 0; k < 8; k++) step("R3", 1, k, 0, 32'h100 + k, '0, 0, 0);
    scan("R3");
    // R4 ninth push overflows
    step("R4", 1, 0, 0, 32'hbad, '0, 0, 0);
    scan("R4");
    // R7 both destinations
    step("R7", 3, 3, 0, '0, 32'haaa0, 0, 0);
    step("R7", 3, 5, 1, '0, 32'haaa5, 0, 0);
    step("R8", 5, 2, 0, '0, 32'hbbb0, 0, 0);
    scan("R7");
    // R10 swap alone and with arithmetic in the same cycle
    step("R10", 0, 4, 0, '0, '0, 1, 4);
    step("R10", 3, 2, 0, '0, 32'hccc0, 1, 2);
    step("R10", 3, 6, 1, '0, 32'hccc6, 1, 6);
    scan("R10");
    // R9 arith then pop, with and without a swap, and i=0
    step("R9", 4, 3, 0, '0, 32'hddd3, 0, 0);
    step("R9", 2, 2, 0, '0, '0, 0, 0);
    step("R9", 4, 2, 0, '0, 32'hddd2, 1, 1);
    step("R9", 4, 0, 0, '0, 32'hddd0, 0, 0);
    scan("R9");
    // R11 swap into an empty slot cancels the main op
    step("R11", 3, 1, 0, '0, 32'heee1, 1, 7);
    step("R11", 1, 0, 0, 32'h777, '0, 1, 7);
    scan("R11");
    // R5 drain and pop past empty
    for (int k = 0; k < 6; k++) step("R5", 2, 1, 0, '0, '0, 0, 0);
    step("R6", 2, 0, 0, '0, '0, 0, 0);
    // R10 push with swap relative to new top
    step("R3", 1, 0, 0, 32'h501, '0, 0, 0);
    step("R10", 1, 1, 0, 32'h502, '0, 1, 1);
    scan("R12");
    // random phase, R12 flags pulse
    for (int n = 0; n < 3000; n++)
      step("R12", int'($urandom_range(0, 6)), int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
           $urandom, $urandom, ($urandom_range(0, 3) == 0), int'($urandom_range(0, 7)));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule